// File: doc/BRIEF.md
# Pin Event Flag and Request Controller

This block watches a bank of already-synchronized input pins and, for each one, turns a chosen pin condition into a sticky status flag. A pin can respond to a rising edge, a falling edge, either edge, a low level or a high level. Depending on the chosen mode, the flag stays local, feeds a shared DMA request line, or feeds one of two interrupt lines. Edges are found by comparing the current level with the level registered one cycle earlier.

Software works through a simple word-addressed write bus with a combinational read port. Each pin has its own control word. Two broadcast words copy one configuration into any subset of sixteen pins in a single write. One status word shows every flag at once and clears any of them with write-one-to-clear. A per-pin lock freezes that pin's configuration until the next reset. A locked pin still sets its flag and can still have it cleared.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After synchronous reset, every pin has mode 0, route bit 0, lock 0 and flag 0. All control and status words read 0, and `irq0_o`, `irq1_o` and `dma_o` are low.
- R2: Edge detection compares the pin level with its level in the previous cycle. Modes 1, 5 and 9 detect a rising edge, modes 2, 6 and 10 a falling edge, and modes 3, 7 and 11 either edge. A detected edge sets the flag, which is visible at the next clock edge.
- R3: Mode 8 sets the flag in every cycle the pin is 0, and mode 12 in every cycle the pin is 1. A clear issued while the level is still present leaves the flag set.
- R4: Modes 0, 4, 13, 14 and 15 never set the flag, whatever the pin does.
- R5: The control word of pin n is at byte address 0x80+4n. Its fields are mode in bits 19:16, interrupt route in bit 20, lock in bit 23 and flag in bit 24, and all other bits read 0.
- R6: Writing 1 to bit 24 of a pin's control word, or to bit n of the status word at 0x120, clears pin n's flag. Writing 0 leaves the flag unchanged. The status word reads the flag of pin n in bit n, and address 0x124 reads 0.
- R7: When a detected event and a clear of the same pin fall in the same cycle, the flag ends up set.
- R8: Once a pin's lock bit is 1, writes to that pin's mode, route and lock fields are ignored until reset. This holds for both direct and broadcast writes. Flag clears still work on a locked pin.
- R9: The broadcast word at 0x100 targets pins 0 to 15 and the one at 0x104 targets pins 16 to 31. Bit k of the 16-bit mask in bits 15:0 selects the k-th pin of the group. Each selected unlocked pin takes the mode, route and lock fields, and a 1 in bit 24 clears the flag of each selected pin. Both broadcast words read 0.
- R10: `irq0_o` is the OR of the flags of pins in modes 8 to 12 with route 0. `irq1_o` is the same for route 1. `dma_o` is the OR of the flags of pins in modes 1 to 3. Flags of pins in modes 5 to 7 drive no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pin_i | input | NUM_PINS | Synchronized pin levels |
| bus_wr | input | 1 | Write strobe for the addressed word |
| bus_addr | input | ADDR_W | Byte address, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data of the addressed word |
| irq0_o | output | 1 | Interrupt line for route 0 |
| irq1_o | output | 1 | Interrupt line for route 1 |
| dma_o | output | 1 | DMA request |

## Verification
The two actions that can collide are a detected pin event and a software clear of the same flag, arriving through either the status word, the control word or a broadcast word. The bench forces this collision on purpose: it toggles a pin in an either-edge mode in the same cycle that it writes 1 to that pin's status bit. It also holds a level-mode pin at its active level while clearing it. In both cases it expects the flag to survive. Random traffic mixes pin toggles with all three kinds of write, so collisions also arise by chance. Every such cycle is judged against a cycle-accurate reference model in the bench in which set wins over clear.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    localparam int CTRL_BASE = 'h80;
    localparam int BCST_BASE = 'h100;
    localparam int STAT_BASE = 'h120;
    localparam int GROUP_W   = 16;

    localparam int MODE_LSB  = 16;
    localparam int ROUTE_BIT = 20;
    localparam int LOCK_BIT  = 23;
    localparam int FLAG_BIT  = 24;

    typedef enum logic [1:0] {
        CLS_NONE,
        CLS_DMA,
        CLS_LOCAL,
        CLS_IRQ
    } evt_class_e;

    typedef struct packed {
        logic       lock;
        logic       route;
        logic [3:0] mode;
    } pin_cfg_t;

    function automatic evt_class_e mode_class(input logic [3:0] m);
        case (m)
            4'd1, 4'd2, 4'd3:                 return CLS_DMA;
            4'd5, 4'd6, 4'd7:                 return CLS_LOCAL;
            4'd8, 4'd9, 4'd10, 4'd11, 4'd12:  return CLS_IRQ;
            default:                          return CLS_NONE;
        endcase
    endfunction

    function automatic logic detect(input logic [3:0] m, input logic now, input logic prev);
        case (m)
            4'd1, 4'd5, 4'd9:   return now & ~prev;
            4'd2, 4'd6, 4'd10:  return ~now & prev;
            4'd3, 4'd7, 4'd11:  return now ^ prev;
            4'd8:               return ~now;
            4'd12:              return now;
            default:            return 1'b0;
        endcase
    endfunction

    function automatic pin_cfg_t cfg_from_word(input logic [31:0] w);
        pin_cfg_t c;
        c.mode  = w[MODE_LSB +: 4];
        c.route = w[ROUTE_BIT];
        c.lock  = w[LOCK_BIT];
        return c;
    endfunction

    function automatic logic [31:0] word_from_cfg(input pin_cfg_t c, input logic flag);
        logic [31:0] w;
        w = '0;
        w[MODE_LSB +: 4] = c.mode;
        w[ROUTE_BIT]     = c.route;
        w[LOCK_BIT]      = c.lock;
        w[FLAG_BIT]      = flag;
        return w;
    endfunction

endpackage

// File: rtl/gpio_irq_decode.sv
module gpio_irq_decode
    import gpio_irq_pkg::*;
#(
    parameter int NUM_PINS = 32,
    parameter int ADDR_W   = 9
) (
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [31:0]         bus_wdata,
    output pin_cfg_t            cfg_wr,
    output logic [NUM_PINS-1:0] cfg_we,
    output logic [NUM_PINS-1:0] flag_clr
);

    logic unused_wdata;
    assign unused_wdata = ^{bus_wdata[31:25], bus_wdata[22:21]};

    assign cfg_wr = cfg_from_word(bus_wdata);

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
        localparam int GRP = i / GROUP_W;
        localparam int SEL = i % GROUP_W;
        logic hit_ctrl, hit_bcst, hit_stat;

        assign hit_ctrl = (bus_addr == ADDR_W'(CTRL_BASE + 4 * i));
        assign hit_bcst = (bus_addr == ADDR_W'(BCST_BASE + 4 * GRP)) && bus_wdata[SEL];
        assign hit_stat = (bus_addr == ADDR_W'(STAT_BASE)) && bus_wdata[i];

        assign cfg_we[i]   = bus_wr && (hit_ctrl || hit_bcst);
        assign flag_clr[i] = bus_wr && (((hit_ctrl || hit_bcst) && bus_wdata[FLAG_BIT]) || hit_stat);
    end

endmodule

// File: rtl/gpio_irq_pin.sv
module gpio_irq_pin
    import gpio_irq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     pin,
    input  logic     cfg_we,
    input  pin_cfg_t cfg_wr,
    input  logic     flag_clr,
    output pin_cfg_t cfg_q,
    output logic     flag_q
);

    logic prev_q;
    logic event_hit;

    assign event_hit = detect(cfg_q.mode, pin, prev_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q  <= '0;
            flag_q <= 1'b0;
            prev_q <= pin;
        end else begin
            prev_q <= pin;
            flag_q <= (flag_q & ~flag_clr) | event_hit;
            if (cfg_we && !cfg_q.lock) begin
                cfg_q <= cfg_wr;
            end
        end
    end

endmodule

// File: rtl/gpio_irq_route.sv
module gpio_irq_route
    import gpio_irq_pkg::*;
#(
    parameter int NUM_PINS = 32
) (
    input  pin_cfg_t [NUM_PINS-1:0] cfg,
    input  logic [NUM_PINS-1:0]     flag,
    output logic                    irq0,
    output logic                    irq1,
    output logic                    dma
);

    always_comb begin
        irq0 = 1'b0;
        irq1 = 1'b0;
        dma  = 1'b0;
        for (int i = 0; i < NUM_PINS; i++) begin
            if (flag[i]) begin
                case (mode_class(cfg[i].mode))
                    CLS_IRQ: begin
                        if (cfg[i].route) irq1 = 1'b1;
                        else              irq0 = 1'b1;
                    end
                    CLS_DMA: dma = 1'b1;
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
    import gpio_irq_pkg::*;
#(
    parameter int NUM_PINS = 32,
    parameter int ADDR_W   = 9
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_PINS-1:0] pin_i,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    output logic                irq0_o,
    output logic                irq1_o,
    output logic                dma_o
);

    localparam int MODE_VEC_W = 4 * NUM_PINS;

    pin_cfg_t                cfg_wr;
    logic [NUM_PINS-1:0]     cfg_we;
    logic [NUM_PINS-1:0]     flag_clr;
    pin_cfg_t [NUM_PINS-1:0] cfg_q;
    logic [NUM_PINS-1:0]     flag_q;
    logic [NUM_PINS-1:0]     lock_vec;
    logic [MODE_VEC_W-1:0]   mode_vec;

    gpio_irq_decode #(
        .NUM_PINS (NUM_PINS),
        .ADDR_W   (ADDR_W)
    ) u_decode (
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .cfg_wr   (cfg_wr),
        .cfg_we   (cfg_we),
        .flag_clr (flag_clr)
    );

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_cell
        gpio_irq_pin u_pin (
            .clk     (clk),
            .rst     (rst),
            .pin     (pin_i[i]),
            .cfg_we  (cfg_we[i]),
            .cfg_wr  (cfg_wr),
            .flag_clr(flag_clr[i]),
            .cfg_q   (cfg_q[i]),
            .flag_q  (flag_q[i])
        );
        assign lock_vec[i]       = cfg_q[i].lock;
        assign mode_vec[4*i +: 4] = cfg_q[i].mode;
    end

    gpio_irq_route #(
        .NUM_PINS(NUM_PINS)
    ) u_route (
        .cfg (cfg_q),
        .flag(flag_q),
        .irq0(irq0_o),
        .irq1(irq1_o),
        .dma (dma_o)
    );

    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < NUM_PINS; i++) begin
            if (bus_addr == ADDR_W'(CTRL_BASE + 4 * i)) begin
                bus_rdata = word_from_cfg(cfg_q[i], flag_q[i]);
            end
        end
        if (bus_addr == ADDR_W'(STAT_BASE)) begin
            bus_rdata = 32'(flag_q);
        end
    end

endmodule

// File: rtl/gpio_irq_chk.sv
module gpio_irq_chk
    import gpio_irq_pkg::*;
#(
    parameter int NUM_PINS = 32,
    parameter int ADDR_W   = 9
) (
    input logic                  clk,
    input logic                  rst,
    input logic [ADDR_W-1:0]     bus_addr,
    input logic [31:0]           bus_rdata,
    input logic                  irq0_o,
    input logic                  irq1_o,
    input logic                  dma_o,
    input logic [NUM_PINS-1:0]   flag_q,
    input logic [NUM_PINS-1:0]   lock_vec,
    input logic [4*NUM_PINS-1:0] mode_vec
);

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (!irq0_o && !irq1_o && !dma_o && flag_q == '0)); // R1

    AST_OUT_NEEDS_FLAG: assert property (@(posedge clk) disable iff (rst)
        (irq0_o || irq1_o || dma_o) |-> (flag_q != '0)); // R10

    AST_BCST_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == ADDR_W'(BCST_BASE) || bus_addr == ADDR_W'(BCST_BASE + 4)) |-> (bus_rdata == 32'd0)); // R9

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin_chk
        AST_LOCK_FREEZES: assert property (@(posedge clk) disable iff (rst)
            lock_vec[i] |=> (lock_vec[i] && mode_vec[4*i +: 4] == $past(mode_vec[4*i +: 4]))); // R8

        AST_IDLE_MODE_NO_FLAG: assert property (@(posedge clk) disable iff (rst)
            $rose(flag_q[i]) |-> (mode_class($past(mode_vec[4*i +: 4])) != CLS_NONE)); // R4
    end

endmodule

bind gpio_irq_ctrl gpio_irq_chk #(
    .NUM_PINS(NUM_PINS),
    .ADDR_W  (ADDR_W)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .bus_addr (bus_addr),
    .bus_rdata(bus_rdata),
    .irq0_o   (irq0_o),
    .irq1_o   (irq1_o),
    .dma_o    (dma_o),
    .flag_q   (flag_q),
    .lock_vec (lock_vec),
    .mode_vec (mode_vec)
);

// File: tb/gpio_irq_ctrl_tb.sv
`timescale 1ns/1ps
module gpio_irq_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] pin_i = '0;
    logic        bus_wr = 1'b0;
    logic [8:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq0_o, irq1_o, dma_o;

    int n_run = 0;
    int n_fail = 0;

    logic [3:0] m_mode [32];
    bit         m_route [32];
    bit         m_lock [32];
    bit         m_flag [32];
    bit         m_prev [32];
    logic [31:0] pv = '0;

    always #4 clk = ~clk;

    gpio_irq_ctrl u_dut (
        .clk(clk), .rst(rst), .pin_i(pin_i), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq0_o(irq0_o), .irq1_o(irq1_o), .dma_o(dma_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic bit m_event(input logic [3:0] md, input bit now, input bit prev);
        case (md)
            4'd1, 4'd5, 4'd9:  return now && !prev;
            4'd2, 4'd6, 4'd10: return !now && prev;
            4'd3, 4'd7, 4'd11: return now != prev;
            4'd8:              return !now;
            4'd12:             return now;
            default:           return 1'b0;
        endcase
    endfunction

    function automatic logic [31:0] exp_read(input logic [8:0] a);
        logic [31:0] r;
        r = '0;
        for (int i = 0; i < 32; i++) begin
            if (a == 9'(32'h80 + 4 * i)) begin
                r[19:16] = m_mode[i];
                r[20] = m_route[i];
                r[23] = m_lock[i];
                r[24] = m_flag[i];
            end
            if (a == 9'h120) r[i] = m_flag[i];
        end
        return r;
    endfunction

    function automatic logic [2:0] exp_outs();
        logic [2:0] o;
        o = '0;
        for (int i = 0; i < 32; i++) begin
            if (m_flag[i] && m_mode[i] >= 4'd8 && m_mode[i] <= 4'd12) begin
                if (m_route[i]) o[1] = 1'b1; else o[0] = 1'b1;
            end
            if (m_flag[i] && m_mode[i] >= 4'd1 && m_mode[i] <= 4'd3) o[2] = 1'b1;
        end
        return o;
    endfunction

    task automatic do_reset();
        rst = 1'b1;
        bus_wr = 1'b0;
        pin_i = pv;
        repeat (3) @(posedge clk);
        #2;
        for (int i = 0; i < 32; i++) begin
            m_mode[i] = '0; m_route[i] = 0; m_lock[i] = 0; m_flag[i] = 0; m_prev[i] = pv[i];
        end
        rst = 1'b0;
    endtask

    // One clock of stimulus, reference model update and output comparison.
    task automatic step(input bit wr, input logic [8:0] a, input logic [31:0] d);
        bus_wr = wr; bus_addr = a; bus_wdata = d; pin_i = pv;
        for (int i = 0; i < 32; i++) begin
            bit hc, hb, hs, we, clr, ev;
            hc  = (a == 9'(32'h80 + 4 * i));
            hb  = (a == 9'(32'h100 + 4 * (i / 16))) && d[i % 16];
            hs  = (a == 9'h120) && d[i];
            we  = wr && (hc || hb);
            clr = wr && (((hc || hb) && d[24]) || hs);
            ev  = m_event(m_mode[i], pv[i], m_prev[i]);
            m_flag[i] = (m_flag[i] && !clr) || ev;
            if (we && !m_lock[i]) begin
                m_mode[i] = d[19:16]; m_route[i] = d[20]; m_lock[i] = d[23];
            end
            m_prev[i] = pv[i];
        end
        @(posedge clk);
        #2;
        bus_wr = 1'b0;
        chk("R10 outputs", {29'd0, dma_o, irq1_o, irq0_o}, {29'd0, exp_outs()});
        chk("R5 R6 readback", bus_rdata, exp_read(a));
    endtask

    task automatic rd(input logic [8:0] a);
        step(0, a, 32'd0);
    endtask

    initial begin
        #(8 * 200000);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        do_reset();

        // R1 reset state
        rd(9'h80 + 9'd124);
        chk("R1 ctrl after reset", bus_rdata, 32'd0);
        chk("R1 outputs after reset", {29'd0, dma_o, irq1_o, irq0_o}, 32'd0);
        rd(9'h120);
        chk("R1 status after reset", bus_rdata, 32'd0);

        // R5 field layout: pin 3, mode 9, route 1
        step(1, 9'h8C, 32'h0019_0000);
        rd(9'h8C);
        chk("R5 ctrl layout", bus_rdata, 32'h0019_0000);

        // R2 rising edge raises route-1 interrupt
        pv[3] = 1'b1;
        rd(9'h120);
        chk("R2 rise sets flag", bus_rdata, 32'h0000_0008);
        chk("R10 route 1 line", {30'd0, irq1_o, irq0_o}, 32'd2);

        // R6 write 0 keeps, write 1 clears
        step(1, 9'h120, 32'd0);
        chk("R6 zero write keeps flag", {31'd0, irq1_o}, 32'd1);
        step(1, 9'h120, 32'h0000_0008);
        chk("R6 one write clears flag", {31'd0, irq1_o}, 32'd0);

        // R7 edge and clear collide on pin 5 (mode 11, route 0)
        step(1, 9'h94, 32'h000B_0000);
        pv[5] = 1'b1;
        step(1, 9'h120, 32'h0000_0020);
        chk("R7 set wins over clear", {31'd0, irq0_o}, 32'd1);
        step(1, 9'h94, 32'h010B_0000);
        chk("R6 ctrl flag clear", {31'd0, irq0_o}, 32'd0);

        // R3 low level on pin 7 re-sets after clear
        step(1, 9'h9C, 32'h0008_0000);
        rd(9'h120);
        step(1, 9'h9C, 32'h0108_0000);
        rd(9'h120);
        chk("R3 level re-sets flag", {31'd0, bus_rdata[7]}, 32'd1);
        pv[7] = 1'b1;
        rd(9'h120);
        step(1, 9'h120, 32'h0000_0080);
        rd(9'h120);
        chk("R3 level gone flag clears", {31'd0, bus_rdata[7]}, 32'd0);

        // R4 mode 4 and 14 ignore edges
        step(1, 9'hAC, 32'h0004_0000);
        step(1, 9'hB8, 32'h000E_0000);
        pv[11] = 1'b1; pv[14] = 1'b1; rd(9'h120);
        pv[11] = 1'b0; pv[14] = 1'b0; rd(9'h120);
        chk("R4 idle modes no flag", {30'd0, bus_rdata[14], bus_rdata[11]}, 32'd0);

        // R10 DMA mode on pin 12, local-only mode on pin 13
        step(1, 9'hB0, 32'h0001_0000);
        step(1, 9'hB4, 32'h0007_0000);
        pv[13] = 1'b1; rd(9'h120);
        chk("R10 local mode drives nothing", {29'd0, dma_o, irq1_o, irq0_o}, 32'd0);
        pv[12] = 1'b1; rd(9'h120);
        chk("R10 dma request", {31'd0, dma_o}, 32'd1);

        // R8 lock pin 9 in mode 5
        step(1, 9'hA4, 32'h0085_0000);
        step(1, 9'hA4, 32'h0000_0000);
        step(1, 9'h100, 32'h0000_0200);
        rd(9'hA4);
        chk("R8 locked config kept", bus_rdata, 32'h0085_0000);
        pv[9] = 1'b1; rd(9'hA4);
        step(1, 9'hA4, 32'h0100_0000);
        rd(9'hA4);
        chk("R8 clear on locked pin", bus_rdata, 32'h0085_0000);

        // R9 broadcast to pins 16 and 17
        step(1, 9'h104, 32'h0009_0003);
        rd(9'h80 + 9'd64);
        chk("R9 broadcast pin 16", bus_rdata, 32'h0009_0000);
        rd(9'h80 + 9'd72);
        chk("R9 unselected pin 18", bus_rdata, 32'h0000_0000);
        rd(9'h104);
        chk("R9 broadcast reads zero", bus_rdata, 32'd0);

        // Random traffic
        for (int n = 0; n < 4000; n++) begin
            int kind;
            logic [31:0] d;
            logic [8:0] a;
            bit wr;
            pv = pv ^ ($urandom & $urandom & $urandom);
            kind = $urandom % 6;
            d = '0;
            d[19:16] = 4'($urandom);
            d[20] = 1'($urandom);
            d[23] = (($urandom % 40) == 0);
            d[24] = 1'($urandom);
            wr = 1'b1;
            case (kind)
                0, 1: a = 9'(32'h80 + 4 * ($urandom % 32));
                2: begin a = (($urandom % 2) == 0) ? 9'h100 : 9'h104; d[15:0] = 16'($urandom); end
                3: begin a = 9'h120; d = $urandom; end
                4: begin wr = 1'b0; a = 9'h120; end
                default: begin wr = 1'b0; a = 9'(32'h80 + 4 * ($urandom % 32)); end
            endcase
            step(wr, a, d);
        end

        // R1 reset after activity
        do_reset();
        rd(9'h120);
        chk("R1 status after second reset", bus_rdata, 32'd0);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule